// File: doc/BRIEF.md
# Isochronous IN Endpoint Double Buffer

This block holds outgoing data for one isochronous IN endpoint. It has two packet stores. In any frame one store is open to the local processor, which loads the next packet byte by byte and then seals it with a commit strobe. The other store is the one the serial interface engine reads. When an IN token arrives, that store is streamed out on a valid/ready byte interface, and the final byte is flagged with last.

A start-of-frame pulse swaps the roles of the two stores and raises a level interrupt, so the processor knows to load the packet for the following frame. Isochronous traffic has no acknowledge, so nothing is kept for a retry. Every packet leaves exactly one frame after it was loaded. A store that was never sealed goes out as a zero-length packet. Loading beyond capacity is dropped and recorded in a sticky flag.

Top module: `iso_in_pingpong`

## Requirements
- R1: After reset `irq`, `ovf` and `tx_valid` are low. An IN token before the first start-of-frame produces a zero-length packet.
- R2: Processor writes land only in the fill store. Bytes written and committed during one frame are not sent in that frame. They are sent after the next `sof`.
- R3: An IN token while idle starts a stream of exactly the committed byte count, in write order. `tx_valid` stays high and `tx_data`/`tx_last` stay stable until `tx_ready` is sampled high. `tx_last` is high on the final byte only, and `tx_valid` is low in the cycle after the last byte is accepted.
- R4: Each `sof` pulse exchanges the two stores. The new fill store starts empty and unsealed.
- R5: `sof` sets `irq` on the next clock. `irq` stays high until an `irq_clr` pulse. When `sof` and `irq_clr` coincide, `irq` ends high.
- R6: When the transmit store holds zero bytes, an IN token yields one beat with `tx_valid`, `tx_last` and `tx_zlp` all high. `tx_zlp` is low on every beat that carries data.
- R7: The store holds `BUF_BYTES` bytes. An unsealed write into a full store is dropped and sets `ovf`. `ovf` stays high until `ovf_clr`.
- R8: A second IN token in the same frame resends the transmit store from its first byte. An IN token that arrives while a stream is in progress is ignored.
- R9: Only a committed store is sent. A store that is not committed when `sof` arrives becomes a zero-length packet. Writes after `commit` in the same frame are dropped and do not set `ovf`.
- R10: `sof` ends any stream in progress, so `tx_valid` is low in the next cycle. An IN token or a processor write in the same cycle as `sof` is ignored.
- R11: If a further `sof` passes with no new commit, the next IN token yields a zero-length packet. Old data is never resent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wdata | input | 8 | Byte to append to the fill store |
| cpu_we | input | 1 | Write strobe, one byte per cycle |
| cpu_commit | input | 1 | Seals the fill store for sending |
| irq_clr | input | 1 | Write-one-to-clear pulse for `irq` |
| ovf_clr | input | 1 | Clear pulse for `ovf` |
| sof | input | 1 | Start-of-frame pulse |
| in_token | input | 1 | IN token received pulse |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing beat present |
| tx_ready | input | 1 | Engine accepts the beat |
| tx_last | output | 1 | Final beat of the packet |
| tx_zlp | output | 1 | Beat marks a zero-length packet |
| irq | output | 1 | Frame interrupt request |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench targets the one-frame delay. A design that swapped on packet completion would send freshly written data in the same frame. The bench checks that an unsealed store and a stale store both go out as zero-length packets. A design that kept the old count would resend the previous frame's data. It runs streams with random back-pressure to catch a pointer that moves while stalled. It also sends a start-of-frame mid-stream, a token mid-stream, and tokens or writes coincident with start-of-frame. A wrong priority there shows up as extra beats, restarted data or a stray byte at the head of the next packet.

// File: rtl/iso_pkg.sv
package iso_pkg;
  typedef enum logic [0:0] {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;

  typedef struct packed {
    logic make_fill;
    logic make_tx;
    logic wr_en;
    logic commit;
    logic is_fill;
  } bank_ctl_t;
endpackage

// File: rtl/iso_bank.sv
module iso_bank #(
  parameter  int BUF_BYTES = 64,
  parameter  int DATA_W    = 8,
  localparam int PTR_W     = $clog2(BUF_BYTES),
  localparam int CNT_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  iso_pkg::bank_ctl_t   ctl,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [PTR_W-1:0]     rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic [CNT_W-1:0]     count,
  output logic                 full_drop
);
  logic [DATA_W-1:0] mem_q [BUF_BYTES];
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              seal_q, seal_d;
  logic              accept;
  logic              has_room;

  assign has_room  = (cnt_q < CNT_W'(BUF_BYTES));
  assign accept    = ctl.wr_en && ctl.is_fill && !seal_q && has_room &&
                     !ctl.make_fill && !ctl.make_tx;
  assign full_drop = ctl.wr_en && ctl.is_fill && !seal_q && !has_room &&
                     !ctl.make_fill && !ctl.make_tx;

  always_comb begin
    cnt_d  = cnt_q;
    seal_d = seal_q;
    if (ctl.make_fill) begin
      cnt_d  = '0;
      seal_d = 1'b0;
    end else if (ctl.make_tx) begin
      if (!seal_q) cnt_d = '0;
    end else begin
      if (accept) cnt_d = cnt_q + 1'b1;
      if (ctl.commit && ctl.is_fill) seal_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seal_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seal_q <= seal_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem_q[cnt_q[PTR_W-1:0]] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];
  assign count   = cnt_q;

  // R2: the store being sent never sees a write or a seal
  p_fill_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.wr_en || ctl.commit) |-> ctl.is_fill);

  // R7: count never passes capacity
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(BUF_BYTES));

  // R4: a store that becomes the fill store starts empty
  p_fill_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.make_fill |=> (cnt_q == '0) && !seal_q);

  // R9: a sealed store stops growing
  p_sealed_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seal_q && !ctl.make_fill && !ctl.make_tx) |=> $stable(cnt_q));
endmodule

// File: rtl/iso_tx_stream.sv
module iso_tx_stream #(
  parameter  int BUF_BYTES = 64,
  parameter  int DATA_W    = 8,
  localparam int PTR_W     = $clog2(BUF_BYTES),
  localparam int CNT_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               abort,
  input  logic [CNT_W-1:0]   count,
  input  logic [DATA_W-1:0]  rd_data,
  output logic [PTR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]  tx_data,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic               tx_last,
  output logic               tx_zlp
);
  import iso_pkg::*;

  tx_state_e        st_q, st_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             sending;
  logic             empty;
  logic             at_end;
  logic [CNT_W-1:0] last_idx;

  assign sending  = (st_q == TX_SEND);
  assign empty    = (count == '0);
  assign last_idx = count - 1'b1;
  assign at_end   = empty || (CNT_W'(ptr_q) == last_idx);

  always_comb begin
    st_d  = st_q;
    ptr_d = ptr_q;
    unique case (st_q)
      TX_IDLE: begin
        if (start && !abort) begin
          st_d  = TX_SEND;
          ptr_d = '0;
        end
      end
      TX_SEND: begin
        if (abort) begin
          st_d  = TX_IDLE;
          ptr_d = '0;
        end else if (tx_ready) begin
          if (at_end) begin
            st_d  = TX_IDLE;
            ptr_d = '0;
          end else begin
            ptr_d = ptr_q + 1'b1;
          end
        end
      end
      default: st_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_IDLE;
      ptr_q <= '0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
    end
  end

  assign rd_addr  = ptr_q;
  assign tx_valid = sending;
  assign tx_last  = sending && at_end;
  assign tx_zlp   = sending && empty;
  assign tx_data  = (sending && !empty) ? rd_data : '0;

  // R3: a stalled beat holds its content
  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !abort) |=>
      (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R3: the stream drops valid right after its last beat
  p_end_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> !tx_valid);

  // R10: start-of-frame ends any stream
  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !tx_valid);

  // R6: a zero-length beat is the only beat of its packet
  p_zlp_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_zlp && tx_ready) |=> !tx_valid);
endmodule

// File: rtl/iso_sticky.sv
module iso_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  // R5 and R7: a set event wins and the flag holds without a clear
  p_set_wins_r5_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  p_hold_r5_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/iso_in_pingpong.sv
module iso_in_pingpong #(
  parameter  int BUF_BYTES = 64,
  parameter  int DATA_W    = 8,
  localparam int PTR_W     = $clog2(BUF_BYTES),
  localparam int CNT_W     = $clog2(BUF_BYTES + 1),
  localparam int NBANK     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  input  logic              cpu_commit,
  input  logic              irq_clr,
  input  logic              ovf_clr,
  input  logic              sof,
  input  logic              in_token,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_last,
  output logic              tx_zlp,
  output logic              irq,
  output logic              ovf
);
  import iso_pkg::*;

  logic              rst_s1_q, rst_s2_q;
  logic              rst_ni;
  logic              fill_sel_q, fill_sel_d;
  logic              tx_sel;
  logic [PTR_W-1:0]  rd_addr;
  logic [DATA_W-1:0] bank_rd   [NBANK];
  logic [CNT_W-1:0]  bank_cnt  [NBANK];
  logic [NBANK-1:0]  bank_drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_ni = rst_s2_q;

  always_comb begin
    fill_sel_d = fill_sel_q;
    if (sof) fill_sel_d = ~fill_sel_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) fill_sel_q <= 1'b0;
    else         fill_sel_q <= fill_sel_d;
  end

  assign tx_sel = ~fill_sel_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    bank_ctl_t ctl;
    always_comb begin
      ctl.is_fill   = (fill_sel_q == 1'(b));
      ctl.make_fill = sof && !ctl.is_fill;
      ctl.make_tx   = sof && ctl.is_fill;
      ctl.wr_en     = cpu_we && !sof && ctl.is_fill;
      ctl.commit    = cpu_commit && !sof && ctl.is_fill;
    end

    iso_bank #(
      .BUF_BYTES (BUF_BYTES),
      .DATA_W    (DATA_W)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_ni),
      .ctl       (ctl),
      .wr_data   (cpu_wdata),
      .rd_addr   (rd_addr),
      .rd_data   (bank_rd[b]),
      .count     (bank_cnt[b]),
      .full_drop (bank_drop[b])
    );
  end

  iso_tx_stream #(
    .BUF_BYTES (BUF_BYTES),
    .DATA_W    (DATA_W)
  ) u_stream (
    .clk      (clk),
    .rst_n    (rst_ni),
    .start    (in_token),
    .abort    (sof),
    .count    (bank_cnt[tx_sel]),
    .rd_data  (bank_rd[tx_sel]),
    .rd_addr  (rd_addr),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_last  (tx_last),
    .tx_zlp   (tx_zlp)
  );

  iso_sticky u_irq (
    .clk   (clk),
    .rst_n (rst_ni),
    .set   (sof),
    .clr   (irq_clr),
    .flag  (irq)
  );

  iso_sticky u_ovf (
    .clk   (clk),
    .rst_n (rst_ni),
    .set   (|bank_drop),
    .clr   (ovf_clr),
    .flag  (ovf)
  );

  // R4: every start-of-frame flips the roles
  p_swap_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    sof |=> (fill_sel_q != $past(fill_sel_q)));

  // R4: roles hold between frames
  p_roles_hold_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    !sof |=> $stable(fill_sel_q));

  // R5: start-of-frame raises the request
  p_irq_on_sof_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    sof |=> irq);

  // R10: a token in the start-of-frame cycle starts nothing
  p_token_on_sof_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (sof && !tx_valid) |=> !tx_valid);
endmodule

// File: tb/tb_iso_in_pingpong.sv
`timescale 1ns/1ps
module tb_iso_in_pingpong;
  localparam int NB = 64;

  logic       clk;
  logic       rst_n;
  logic [7:0] cpu_wdata;
  logic       cpu_we, cpu_commit, irq_clr, ovf_clr, sof, in_token, tx_ready;
  logic [7:0] tx_data;
  logic       tx_valid, tx_last, tx_zlp, irq, ovf;

  iso_in_pingpong #(.BUF_BYTES(NB), .DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
    .cpu_commit(cpu_commit), .irq_clr(irq_clr), .ovf_clr(ovf_clr),
    .sof(sof), .in_token(in_token), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_last(tx_last), .tx_zlp(tx_zlp),
    .irq(irq), .ovf(ovf)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // reference model
  logic [7:0] f_mem [NB];
  logic [7:0] t_mem [NB];
  int         f_cnt = 0;
  int         t_cnt = 0;
  bit         f_cm  = 0;
  bit         e_irq = 0;
  bit         e_ovf = 0;

  function automatic bit exp_last(input int idx);
    return (t_cnt == 0) || (idx == t_cnt - 1);
  endfunction

  function automatic logic [10:0] exp_beat(input int idx);
    return {1'b1, exp_last(idx), (t_cnt == 0), (t_cnt == 0) ? 8'h00 : t_mem[idx]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_sof();
    if (f_cm) begin
      for (int i = 0; i < NB; i++) t_mem[i] = f_mem[i];
      t_cnt = f_cnt;
    end else begin
      t_cnt = 0;
    end
    f_cnt = 0;
    f_cm  = 0;
    e_irq = 1;
  endtask

  task automatic cpu_wr(input logic [7:0] d);
    cpu_wdata = d;
    cpu_we    = 1'b1;
    @(negedge clk);
    cpu_we    = 1'b0;
    if (!f_cm) begin
      if (f_cnt < NB) begin
        f_mem[f_cnt] = d;
        f_cnt++;
      end else begin
        e_ovf = 1;
      end
    end
  endtask

  task automatic do_commit();
    cpu_commit = 1'b1;
    @(negedge clk);
    cpu_commit = 1'b0;
    f_cm = 1;
  endtask

  task automatic do_sof(input bit with_clr);
    sof     = 1'b1;
    irq_clr = with_clr;
    @(negedge clk);
    sof     = 1'b0;
    irq_clr = 1'b0;
    model_sof();
  endtask

  task automatic clr_flags(input bit ci, input bit co);
    irq_clr = ci;
    ovf_clr = co;
    @(negedge clk);
    irq_clr = 1'b0;
    ovf_clr = 1'b0;
    if (ci) e_irq = 0;
    if (co) e_ovf = 0;
  endtask

  task automatic load_pkt(input int len, input bit seal);
    for (int i = 0; i < len; i++) cpu_wr(8'($urandom));
    if (seal) do_commit();
  endtask

  // token, then collect the stream under random or full back-pressure
  task automatic fetch(input string req, input bit always_rdy, input bit poke);
    int  idx;
    bit  rdy;
    bit  bad;
    in_token = 1'b1;
    @(negedge clk);
    in_token = 1'b0;
    idx = 0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      bad = ({tx_valid, tx_last, tx_zlp, tx_data} != exp_beat(idx));
      check(!bad, req, "beat", int'({tx_valid, tx_last, tx_zlp, tx_data}),
            int'(exp_beat(idx)));
      if (bad) break;
      rdy = always_rdy ? 1'b1 : ($urandom % 3 != 0);
      tx_ready = rdy;
      if (poke && idx == 1) in_token = 1'b1;
      @(negedge clk);
      in_token = 1'b0;
      tx_ready = 1'b0;
      if (rdy) begin
        if (exp_last(idx)) break;
        idx++;
      end
    end
    check(tx_valid == 1'b0, req, "idle after packet", int'(tx_valid), 0);
  endtask

  task automatic chk_flags(input string req);
    check(irq == e_irq, req, "irq", int'(irq), int'(e_irq));
    check(ovf == e_ovf, req, "ovf", int'(ovf), int'(e_ovf));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2417));
    rst_n = 1'b0;
    cpu_wdata = '0; cpu_we = 0; cpu_commit = 0; irq_clr = 0; ovf_clr = 0;
    sof = 0; in_token = 0; tx_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state and empty first packet
    check(irq == 0, "R1", "irq after reset", int'(irq), 0);
    check(ovf == 0, "R1", "ovf after reset", int'(ovf), 0);
    check(tx_valid == 0, "R1", "tx_valid after reset", int'(tx_valid), 0);
    fetch("R1", 1'b1, 1'b0);

    // R2: committed data is not sent in its own frame
    load_pkt(5, 1'b1);
    fetch("R2", 1'b1, 1'b0);
    do_sof(1'b0);
    check(irq == 1, "R5", "irq after sof", int'(irq), 1);
    repeat (3) @(negedge clk);
    check(irq == 1, "R5", "irq held", int'(irq), 1);
    fetch("R2", 1'b1, 1'b0);

    // R8: resend in same frame, token mid-stream ignored
    fetch("R8", 1'b0, 1'b0);
    fetch("R8", 1'b1, 1'b1);

    // R5: clear then set-wins
    clr_flags(1'b1, 1'b0);
    check(irq == 0, "R5", "irq after clear", int'(irq), 0);
    // R11: no commit -> stale data never resent
    do_sof(1'b1);
    check(irq == 1, "R5", "sof beats irq_clr", int'(irq), 1);
    fetch("R11", 1'b1, 1'b0);

    // R9: unsealed store goes out empty; writes after commit dropped
    load_pkt(7, 1'b0);
    do_sof(1'b0);
    fetch("R9", 1'b1, 1'b0);
    load_pkt(4, 1'b1);
    cpu_wr(8'hA5);
    cpu_wr(8'h5A);
    chk_flags("R9");
    do_sof(1'b0);
    fetch("R9", 0, 0);

    // R7: overflow
    load_pkt(NB + 2, 1'b0);
    check(ovf == 1, "R7", "ovf set", int'(ovf), 1);
    repeat (2) @(negedge clk);
    check(ovf == 1, "R7", "ovf sticky", int'(ovf), 1);
    do_commit();
    do_sof(1'b0);
    fetch("R7", 1'b0, 1'b0);
    clr_flags(1'b1, 1'b1);
    chk_flags("R7");

    // R10: sof aborts a stream; token and write on sof ignored
    load_pkt(12, 1'b1);
    do_sof(1'b0);
    in_token = 1'b1;
    @(negedge clk);
    in_token = 1'b0;
    tx_ready = 1'b1;
    repeat (3) @(negedge clk);
    tx_ready = 1'b0;
    check(tx_valid == 1, "R10", "mid-stream valid", int'(tx_valid), 1);
    do_sof(1'b0);
    check(tx_valid == 0, "R10", "abort on sof", int'(tx_valid), 0);
    load_pkt(3, 1'b1);
    in_token = 1'b1;
    sof = 1'b1;
    cpu_wdata = 8'h77;
    cpu_we = 1'b1;
    @(negedge clk);
    in_token = 1'b0;
    sof = 1'b0;
    cpu_we = 1'b0;
    model_sof();
    check(tx_valid == 0, "R10", "token on sof", int'(tx_valid), 0);
    fetch("R4", 1'b1, 1'b0);
    load_pkt(2, 1'b1);
    do_sof(1'b0);
    fetch("R10", 1'b1, 1'b0);

    // R3 R4 R6: random frames
    for (int fr = 0; fr < 40; fr++) begin
      load_pkt(int'($urandom % 70), ($urandom % 4) != 0);
      chk_flags("R7");
      do_sof(($urandom % 2) == 1);
      fetch((t_cnt == 0) ? "R6" : "R3", 1'b0, 1'b0);
      if ($urandom % 2 == 1) fetch("R8", 1'b0, 1'b0);
      if ($urandom % 3 == 0) clr_flags(1'b1, 1'b1);
      chk_flags("R5");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule